// File: doc/BRIEF.md
# Multi-Mode Mantissa Rounding Stage

This block is one pipeline stage of a floating-point datapath. It takes a sign and a wide mantissa whose two least significant bits carry the guard and round positions, along with a separate sticky bit and a two-bit rounding-mode select. It drops the guard and round positions with a fixed two-bit right shift. When the selected mode and the discarded bits call for it, it adds one at the new least significant bit. The result is registered, so it appears one clock after the inputs are presented.

Besides the rounded mantissa, the stage reports three things:
- an inexact flag, set whenever any discarded information was nonzero;
- a flag saying that an increment was applied;
- the carry out of that increment.

The stage does not renormalise. A mantissa that was all ones before the increment comes out as zero with the carry set, and the surrounding logic must fix up the exponent. The sticky information is fully consumed here and is not passed on.

Top module: `rnd_unit`

## Requirements
- R1: One clock after the inputs are sampled, `mant_o` equals bits [MANT_W-1:2] of `mant_i`, plus one when `up_o` is 1.
- R2: When guard (`mant_i[1]`), round (`mant_i[0]`) and `sticky_i` are all 0, `inexact_o` and `up_o` are 0 and `mant_o` is exactly the shifted input.
- R3: When any of guard, round or sticky is 1, `inexact_o` is 1 in every rounding mode.
- R4: In mode 2'b00 (nearest), there is no increment when guard is 0. With guard at 1, the stage increments when round or sticky is 1. With guard at 1 and both round and sticky at 0, it increments only when the shifted LSB (`mant_i[2]`) is 1, which gives ties-to-even.
- R5: In mode 2'b01 (toward zero), the stage never increments.
- R6: In mode 2'b10 (toward minus infinity), the stage increments on an inexact value only when `sign_i` is 1.
- R7: In mode 2'b11 (toward plus infinity), the stage increments on an inexact value only when `sign_i` is 0.
- R8: An increment carries through the full output width. `carry_o` is 1 exactly when the shifted mantissa was all ones and was incremented, and `mant_o` is then zero.
- R9: `up_o` is 1 exactly when an increment was applied.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value (1 = negative) |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round position |
| mode_i | input | 2 | 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| mant_o | output | MANT_W-2 | Rounded mantissa with guard and round removed |
| carry_o | output | 1 | Carry out of the increment |
| inexact_o | output | 1 | Discarded bits were nonzero |
| up_o | output | 1 | An increment was applied |

## Verification
Each mode is driven with inputs whose guard, round and sticky patterns sit on both sides of its increment decision.

In nearest mode, the guard-only tie is applied with an even shifted LSB and again with an odd one. Only ties-to-even separates those two cases from round-half-up. A sticky-only input and a round-only input separate the guard test from a plain nonzero test.

The directed modes are driven with both signs, which exposes a swapped direction. Increments are also applied to mantissas with runs of trailing ones that end inside the first carry chunk, at a chunk boundary, and across the whole width. These cases show whether the carry travels between chunks and reaches the carry output.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_NEG     = 2'b10,
        RM_POS     = 2'b11
    } rnd_mode_e;

    // Three bits of discarded information seen by the decision logic
    typedef struct packed {
        logic guard;
        logic rnd;
        logic sticky;
    } lost_bits_s;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic       sign_i,
    input  lost_bits_s lost_i,
    input  logic       lsb_i,
    input  logic [1:0] mode_i,
    output logic       inexact_o,
    output logic       inc_o
);

    rnd_mode_e mode;
    logic      any_lost;
    logic      near_inc;

    always_comb begin
        mode     = rnd_mode_e'(mode_i);
        any_lost = lost_i.guard | lost_i.rnd | lost_i.sticky;
        // Nearest: above half, or exact half with an odd kept LSB
        near_inc = lost_i.guard & (lost_i.rnd | lost_i.sticky | lsb_i);
        inexact_o = any_lost;
        unique case (mode)
            RM_NEAREST: inc_o = near_inc;
            RM_ZERO:    inc_o = 1'b0;
            RM_NEG:     inc_o = any_lost & sign_i;
            RM_POS:     inc_o = any_lost & ~sign_i;
            default:    inc_o = near_inc;
        endcase
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int WIDTH = 64,
    parameter int CHUNK = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int NCH = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int PW  = NCH * CHUNK;

    logic [PW-1:0] a_pad;
    logic [PW-1:0] s_pad;
    logic [NCH:0]  cin;

    always_comb begin
        a_pad              = '0;
        a_pad[WIDTH-1:0]   = a_i;
    end

    assign cin[0] = inc_i;

    // Each chunk adds its carry-in; the carry moves on only past an all-ones chunk
    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        logic [CHUNK-1:0] seg;
        assign seg                       = a_pad[g*CHUNK +: CHUNK];
        assign s_pad[g*CHUNK +: CHUNK]   = seg + {{(CHUNK-1){1'b0}}, cin[g]};
        assign cin[g+1]                  = cin[g] & (&seg);
    end

    assign sum_o = s_pad[WIDTH-1:0];

    if (PW > WIDTH) begin : g_cout_pad
        assign cout_o = s_pad[WIDTH];
    end else begin : g_cout_full
        assign cout_o = cin[NCH];
    end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int MANT_W = 66,
    parameter int CHUNK  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sign_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-3:0] mant_o,
    output logic              carry_o,
    output logic              inexact_o,
    output logic              up_o
);

    localparam int OUT_W = MANT_W - 2;

    typedef struct packed {
        logic [OUT_W-1:0] mant;
        logic             carry;
        logic             inexact;
        logic             up;
    } stage_s;

    stage_s           st_d, st_q;
    lost_bits_s       lost;
    logic [OUT_W-1:0] kept;
    logic [OUT_W-1:0] sum;
    logic             cout;
    logic             inexact;
    logic             inc;

    always_comb begin
        kept        = mant_i[MANT_W-1:2];
        lost.guard  = mant_i[1];
        lost.rnd    = mant_i[0];
        lost.sticky = sticky_i;
    end

    rnd_decide u_decide (
        .sign_i    (sign_i),
        .lost_i    (lost),
        .lsb_i     (kept[0]),
        .mode_i    (mode_i),
        .inexact_o (inexact),
        .inc_o     (inc)
    );

    rnd_incr #(
        .WIDTH (OUT_W),
        .CHUNK (CHUNK)
    ) u_incr (
        .a_i    (kept),
        .inc_i  (inc),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_comb begin
        st_d.mant    = sum;
        st_d.carry   = cout;
        st_d.inexact = inexact;
        st_d.up      = inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mant_o    = st_q.mant;
    assign carry_o   = st_q.carry;
    assign inexact_o = st_q.inexact;
    assign up_o      = st_q.up;

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int MANT_W = 66
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sign_i,
    input logic [MANT_W-1:0] mant_i,
    input logic              sticky_i,
    input logic [1:0]        mode_i,
    input logic [MANT_W-3:0] mant_o,
    input logic              carry_o,
    input logic              inexact_o,
    input logic              up_o
);

    localparam int OW = MANT_W - 2;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (rst_n || (mant_o == '0 && !carry_o && !inexact_o && !up_o)));

    p_exact_pass_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mant_i[1:0]) == 2'b00 && !$past(sticky_i)) |-> (!inexact_o && !up_o));

    p_inexact_set_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mant_i[1:0]) != 2'b00 || $past(sticky_i)) |-> inexact_o);

    p_zero_no_inc_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mode_i) == 2'b01) |-> !up_o);

    p_neg_dir_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mode_i) == 2'b10 && !$past(sign_i)) |-> !up_o);

    p_pos_dir_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mode_i) == 2'b11 && $past(sign_i)) |-> !up_o);

    p_near_guard_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(mode_i) == 2'b00 && !$past(mant_i[1])) |-> !up_o);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !up_o |-> (mant_o == $past(mant_i[MANT_W-1:2]) && !carry_o));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        up_o |-> ({carry_o, mant_o} ==
                  ({1'b0, $past(mant_i[MANT_W-1:2])} + {{OW{1'b0}}, 1'b1})));

    p_carry_needs_up_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        carry_o |-> up_o);

endmodule

bind rnd_unit rnd_unit_chk #(.MANT_W(MANT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sign_i    (sign_i),
    .mant_i    (mant_i),
    .sticky_i  (sticky_i),
    .mode_i    (mode_i),
    .mant_o    (mant_o),
    .carry_o   (carry_o),
    .inexact_o (inexact_o),
    .up_o      (up_o)
);

// File: tb/tb_rnd_unit.sv
module tb_rnd_unit;

    localparam int W  = 66;
    localparam int OW = W - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sign_i = 1'b0;
    logic [W-1:0]  mant_i = '0;
    logic          sticky_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [OW-1:0] mant_o;
    logic          carry_o, inexact_o, up_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rnd_unit #(.MANT_W(W)) dut (
        .clk (clk), .rst_n (rst_n), .sign_i (sign_i), .mant_i (mant_i),
        .sticky_i (sticky_i), .mode_i (mode_i), .mant_o (mant_o),
        .carry_o (carry_o), .inexact_o (inexact_o), .up_o (up_o)
    );

    // Expected increment decision taken straight from R4..R7
    function automatic bit want_inc(bit s, logic [W-1:0] m, bit st, logic [1:0] md);
        bit g = m[1];
        bit r = m[0];
        bit lost = g | r | st;
        case (md)
            2'b00:   return g && (r || st || m[2]);
            2'b01:   return 1'b0;
            2'b10:   return lost && s;
            default: return lost && !s;
        endcase
    endfunction

    task automatic check(string req, logic [OW-1:0] em, bit ec, bit ei, bit eu);
        checks++;
        if (mant_o !== em || carry_o !== ec || inexact_o !== ei || up_o !== eu) begin
            errors++;
            $display("FAIL %s: got mant=%h c=%b x=%b u=%b, expected mant=%h c=%b x=%b u=%b",
                     req, mant_o, carry_o, inexact_o, up_o, em, ec, ei, eu);
        end
    endtask

    // Present one input set, wait out the one-cycle latency and compare
    task automatic run(string req, bit s, logic [W-1:0] m, bit st, logic [1:0] md);
        logic [OW:0] full;
        bit inc;
        @(negedge clk);
        sign_i = s; mant_i = m; sticky_i = st; mode_i = md;
        inc  = want_inc(s, m, st, md);
        full = {1'b0, m[W-1:2]} + (inc ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        check(req, full[OW-1:0], full[OW], (m[1:0] != 2'b00) || st, inc);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 reset", '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_exact();
        run("R2 exact nearest", 1'b0, {64'hDEAD_BEEF_0123_4567, 2'b00}, 1'b0, 2'b00);
        run("R2 exact toward plus", 1'b0, {64'h0000_0000_0000_0001, 2'b00}, 1'b0, 2'b11);
        run("R1 shift exact minus", 1'b1, {64'h8000_0000_0000_0003, 2'b00}, 1'b0, 2'b10);
    endtask

    task automatic t_nearest();
        run("R4 guard0 round1", 1'b0, {64'h10, 2'b01}, 1'b0, 2'b00);
        run("R4 guard0 sticky", 1'b0, {64'h11, 2'b00}, 1'b1, 2'b00);
        run("R4 above half", 1'b0, {64'h10, 2'b11}, 1'b0, 2'b00);
        run("R4 guard sticky", 1'b1, {64'h10, 2'b10}, 1'b1, 2'b00);
        run("R4 tie even", 1'b0, {64'h10, 2'b10}, 1'b0, 2'b00);
        run("R4 tie odd", 1'b0, {64'h11, 2'b10}, 1'b0, 2'b00);
    endtask

    task automatic t_directed();
        run("R5 zero pos", 1'b0, {64'h7, 2'b11}, 1'b1, 2'b01);
        run("R5 zero neg", 1'b1, {64'h7, 2'b10}, 1'b0, 2'b01);
        run("R3 sticky only zero", 1'b0, {64'h7, 2'b00}, 1'b1, 2'b01);
        run("R6 minus pos", 1'b0, {64'h20, 2'b01}, 1'b0, 2'b10);
        run("R6 minus neg", 1'b1, {64'h20, 2'b01}, 1'b0, 2'b10);
        run("R7 plus pos", 1'b0, {64'h20, 2'b00}, 1'b1, 2'b11);
        run("R7 plus neg", 1'b1, {64'h20, 2'b00}, 1'b1, 2'b11);
    endtask

    task automatic t_carry();
        run("R8 carry in chunk", 1'b0, {64'h0000_0000_0000_00FF, 2'b11}, 1'b0, 2'b00);
        run("R8 carry chunk edge", 1'b0, {64'h0000_0000_0000_FFFF, 2'b10}, 1'b1, 2'b11);
        run("R8 carry two chunks", 1'b1, {64'h1234_5678_FFFF_FFFF, 2'b01}, 1'b0, 2'b10);
        run("R8 R9 carry out", 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b0, 2'b00);
        run("R9 full ones no inc", 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b0, 2'b01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_exact();
        t_nearest();
        t_directed();
        t_carry();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule